// File: doc/BRIEF.md
# Per-Thread Pipeline Redirect Arbiter

The block sits at the end of an execute group in a multithreaded out-of-order core. Each cycle, up to `L` executed instructions arrive on lanes. Each lane carries a thread number, a sequence number, a PC, a next PC and three squash causes: a resolved branch mispredict, a memory ordering violation, and a load that could not run because memory was blocked. For every thread, the arbiter picks the single cause that must be sent to commit as a redirect. It then presents, one cycle later, the squash flag, the squashed sequence number, the restart PC and the PC after it, and the mispredict, taken and include-squashed-instruction flags.

Lanes are examined in lane order. A recorded redirect can be overridden later in the same group by a cause on an older instruction, so the redirect that survives for a thread is the oldest eligible one. Each kind of cause has its own restart address and its own rule for whether the squashed instruction is itself re-run. A per-thread "blocked load already handled" flag suppresses repeated redirects for the same memory stall. Three free-running counters record taken and not-taken mispredicts and ordering violations.

Top module: `redirect_arbiter`

## Requirements
- R1: Within one group, a cause is recorded for a thread only when that thread has no recorded cause yet in the group, or when its sequence number is strictly smaller (older) than the recorded one; the redirect reported for the thread is the last one recorded, and the record is cleared at every new group.
- R2: When one lane carries several causes, a mispredict takes precedence over an ordering violation, and an ordering violation takes precedence over a blocked load.
- R3: A winning mispredict reports restart PC = the lane's next PC, mispredict flag = 1, include flag = 0, and taken flag = 1 exactly when the next PC differs from PC + INST_BYTES.
- R4: A winning ordering violation reports restart PC = the lane's next PC, with mispredict, taken and include flags all 0.
- R5: A winning blocked load reports restart PC = the lane's own PC, include flag = 1, and mispredict and taken flags 0.
- R6: Whenever squash is reported, the restart next-PC equals restart PC + INST_BYTES.
- R7: A blocked load is a cause only while the thread's handled flag is clear. Any such blocked load sets the flag, whether or not it wins, so a second one in the same group or later is ignored. The thread's `blockRetry` input clears the flag before the group that arrives with it is examined.
- R8: The outputs for a thread appear on the clock edge after its group. A thread with no winning cause reports squash 0 and all its other redirect fields 0.
- R9: `cntTakenMis` / `cntNotTakenMis` increase by the number of mispredict lanes recorded under R1 in the group whose predicted-taken input is 1 / 0.
- R10: `cntViolation` increases by the number of valid lanes that carry a violation without a mispredict, whether or not that violation is recorded.
- R11: After reset every output and counter is 0 and every handled flag is clear.
- R12: Threads are arbitrated independently; a cause on one thread never changes another thread's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| laneValid | input | L | Lane holds an executed instruction |
| laneTid | input | L x TID_W | Thread of each lane |
| laneSeq | input | L x SEQ_W | Sequence number (smaller is older) |
| lanePc | input | L x PC_W | Instruction PC |
| laneNpc | input | L x PC_W | Resolved next PC |
| laneMispred | input | L | Branch resolved against its prediction |
| lanePredTaken | input | L | Branch was predicted taken |
| laneViolation | input | L | Memory ordering violation seen at this instruction |
| laneLoadBlocked | input | L | Load could not run, memory blocked |
| blockRetry | input | NT | Clears the thread's handled flag |
| squashOut | output | NT | Redirect valid per thread |
| squashSeq | output | NT x SEQ_W | Squashed sequence number |
| restartPc | output | NT x PC_W | Restart PC |
| restartNpc | output | NT x PC_W | PC after the restart PC |
| mispredOut | output | NT | Redirect is a branch mispredict |
| takenOut | output | NT | Mispredicted branch was actually taken |
| includeOut | output | NT | Squashed instruction itself is re-executed |
| cntTakenMis | output | CNT_W | Count of taken-predicted mispredicts |
| cntNotTakenMis | output | CNT_W | Count of not-taken-predicted mispredicts |
| cntViolation | output | CNT_W | Count of ordering violations |

## Verification
The assertions and the age rule take for granted that sequence numbers of one thread are distinct within a group and do not wrap, so a smaller value is always the older instruction, and that every valid lane names an existing thread. The random stimulus builds each sequence number from random upper bits with the lane index in the low bits. This keeps them distinct within a group while the age order still varies from lane to lane, and thread numbers are drawn only from the configured range. Directed groups cover overriding by an older lane, several causes on one lane, repeated blocked loads with and without retry, and traffic on one thread only.

// File: rtl/redir_pkg.sv
package redir_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_BRANCH = 2'd1,
    CAUSE_ORDER  = 2'd2,
    CAUSE_LOAD   = 2'd3
  } cause_e;

  // per-thread strobe from control to datapath
  typedef struct packed {
    logic   fire;
    cause_e cause;
  } redirStrobe_t;

endpackage

// File: rtl/redir_ctrl.sv
module redir_ctrl
  import redir_pkg::*;
#(
  parameter int NT     = 2,
  parameter int L      = 4,
  parameter int SEQ_W  = 16,
  parameter int TID_W  = 1,
  parameter int LIDX_W = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [L-1:0]                laneValid,
  input  logic [L-1:0][TID_W-1:0]     laneTid,
  input  logic [L-1:0][SEQ_W-1:0]     laneSeq,
  input  logic [L-1:0]                laneMispred,
  input  logic [L-1:0]                lanePredTaken,
  input  logic [L-1:0]                laneViolation,
  input  logic [L-1:0]                laneLoadBlocked,
  input  logic [NT-1:0]               blockRetry,
  output redirStrobe_t [NT-1:0]       strobe,
  output logic [NT-1:0][LIDX_W-1:0]   winLane,
  output logic [LIDX_W:0]             incTaken,
  output logic [LIDX_W:0]             incNotTaken,
  output logic [LIDX_W:0]             incViol
);

  localparam logic [LIDX_W:0] INC_ONE = 1;

  logic [NT-1:0]            handled, handledNext;
  logic [NT-1:0]            recFlag;
  logic [NT-1:0][SEQ_W-1:0] recSeq;
  logic [TID_W-1:0]         tidV;
  logic                     older;
  cause_e                   laneCause;

  // lanes walked in order; an older cause overrides the group's record (R1)
  always_comb begin
    handledNext = handled & ~blockRetry;
    recFlag     = '0;
    recSeq      = '0;
    strobe      = '0;
    winLane     = '0;
    incTaken    = '0;
    incNotTaken = '0;
    incViol     = '0;
    tidV        = '0;
    older       = 1'b0;
    laneCause   = CAUSE_NONE;
    for (int l = 0; l < L; l++) begin
      if (laneValid[l] && (int'(laneTid[l]) < NT)) begin
        tidV      = laneTid[l];
        older     = !recFlag[tidV] || (laneSeq[l] < recSeq[tidV]);
        laneCause = CAUSE_NONE;
        if (laneMispred[l]) begin
          laneCause = CAUSE_BRANCH;
        end else if (laneViolation[l]) begin
          laneCause = CAUSE_ORDER;
          incViol   = incViol + INC_ONE;
        end else if (laneLoadBlocked[l] && !handledNext[tidV]) begin
          laneCause         = CAUSE_LOAD;
          handledNext[tidV] = 1'b1;
        end
        if (laneCause != CAUSE_NONE && older) begin
          recFlag[tidV]      = 1'b1;
          recSeq[tidV]       = laneSeq[l];
          strobe[tidV].fire  = 1'b1;
          strobe[tidV].cause = laneCause;
          winLane[tidV]      = LIDX_W'(l);
          if (laneCause == CAUSE_BRANCH) begin
            if (lanePredTaken[l]) incTaken    = incTaken + INC_ONE;
            else                  incNotTaken = incNotTaken + INC_ONE;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) handled <= '0;
    else        handled <= handledNext;
  end

endmodule

// File: rtl/redir_dpath.sv
module redir_dpath
  import redir_pkg::*;
#(
  parameter int NT         = 2,
  parameter int L          = 4,
  parameter int SEQ_W      = 16,
  parameter int PC_W       = 32,
  parameter int INST_BYTES = 4,
  parameter int CNT_W      = 16,
  parameter int LIDX_W     = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [L-1:0][SEQ_W-1:0]     laneSeq,
  input  logic [L-1:0][PC_W-1:0]      lanePc,
  input  logic [L-1:0][PC_W-1:0]      laneNpc,
  input  redirStrobe_t [NT-1:0]       strobe,
  input  logic [NT-1:0][LIDX_W-1:0]   winLane,
  input  logic [LIDX_W:0]             incTaken,
  input  logic [LIDX_W:0]             incNotTaken,
  input  logic [LIDX_W:0]             incViol,
  output logic [NT-1:0]               squashOut,
  output logic [NT-1:0][SEQ_W-1:0]    squashSeq,
  output logic [NT-1:0][PC_W-1:0]     restartPc,
  output logic [NT-1:0][PC_W-1:0]     restartNpc,
  output logic [NT-1:0]               mispredOut,
  output logic [NT-1:0]               takenOut,
  output logic [NT-1:0]               includeOut,
  output logic [CNT_W-1:0]            cntTakenMis,
  output logic [CNT_W-1:0]            cntNotTakenMis,
  output logic [CNT_W-1:0]            cntViolation
);

  localparam logic [PC_W-1:0] STEP = PC_W'(INST_BYTES);

  for (genvar t = 0; t < NT; t++) begin : g_thr
    logic [PC_W-1:0]  selPc, selNpc, resPc;
    logic [SEQ_W-1:0] selSeq;
    logic             isBr, isLd;

    assign selPc  = lanePc[winLane[t]];
    assign selNpc = laneNpc[winLane[t]];
    assign selSeq = laneSeq[winLane[t]];
    assign isBr   = strobe[t].cause == CAUSE_BRANCH;
    assign isLd   = strobe[t].cause == CAUSE_LOAD;
    assign resPc  = isLd ? selPc : selNpc;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        squashOut[t]  <= 1'b0;
        squashSeq[t]  <= '0;
        restartPc[t]  <= '0;
        restartNpc[t] <= '0;
        mispredOut[t] <= 1'b0;
        takenOut[t]   <= 1'b0;
        includeOut[t] <= 1'b0;
      end else if (strobe[t].fire) begin
        squashOut[t]  <= 1'b1;
        squashSeq[t]  <= selSeq;
        restartPc[t]  <= resPc;
        restartNpc[t] <= resPc + STEP;
        mispredOut[t] <= isBr;
        takenOut[t]   <= isBr && (selNpc != selPc + STEP);
        includeOut[t] <= isLd;
      end else begin
        squashOut[t]  <= 1'b0;
        squashSeq[t]  <= '0;
        restartPc[t]  <= '0;
        restartNpc[t] <= '0;
        mispredOut[t] <= 1'b0;
        takenOut[t]   <= 1'b0;
        includeOut[t] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntTakenMis    <= '0;
      cntNotTakenMis <= '0;
      cntViolation   <= '0;
    end else begin
      cntTakenMis    <= cntTakenMis + CNT_W'(incTaken);
      cntNotTakenMis <= cntNotTakenMis + CNT_W'(incNotTaken);
      cntViolation   <= cntViolation + CNT_W'(incViol);
    end
  end

endmodule

// File: rtl/redirect_arbiter.sv
module redirect_arbiter
  import redir_pkg::*;
#(
  parameter int NT         = 2,
  parameter int L          = 4,
  parameter int SEQ_W      = 16,
  parameter int PC_W       = 32,
  parameter int INST_BYTES = 4,
  parameter int CNT_W      = 16,
  localparam int TID_W     = (NT > 1) ? $clog2(NT) : 1,
  localparam int LIDX_W    = (L > 1) ? $clog2(L) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [L-1:0]                laneValid,
  input  logic [L-1:0][TID_W-1:0]     laneTid,
  input  logic [L-1:0][SEQ_W-1:0]     laneSeq,
  input  logic [L-1:0][PC_W-1:0]      lanePc,
  input  logic [L-1:0][PC_W-1:0]      laneNpc,
  input  logic [L-1:0]                laneMispred,
  input  logic [L-1:0]                lanePredTaken,
  input  logic [L-1:0]                laneViolation,
  input  logic [L-1:0]                laneLoadBlocked,
  input  logic [NT-1:0]               blockRetry,
  output logic [NT-1:0]               squashOut,
  output logic [NT-1:0][SEQ_W-1:0]    squashSeq,
  output logic [NT-1:0][PC_W-1:0]     restartPc,
  output logic [NT-1:0][PC_W-1:0]     restartNpc,
  output logic [NT-1:0]               mispredOut,
  output logic [NT-1:0]               takenOut,
  output logic [NT-1:0]               includeOut,
  output logic [CNT_W-1:0]            cntTakenMis,
  output logic [CNT_W-1:0]            cntNotTakenMis,
  output logic [CNT_W-1:0]            cntViolation
);

  redirStrobe_t [NT-1:0]     strobe;
  logic [NT-1:0][LIDX_W-1:0] winLane;
  logic [LIDX_W:0]           incTaken, incNotTaken, incViol;

  redir_ctrl #(
    .NT(NT), .L(L), .SEQ_W(SEQ_W), .TID_W(TID_W), .LIDX_W(LIDX_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .laneValid(laneValid), .laneTid(laneTid), .laneSeq(laneSeq),
    .laneMispred(laneMispred), .lanePredTaken(lanePredTaken),
    .laneViolation(laneViolation), .laneLoadBlocked(laneLoadBlocked),
    .blockRetry(blockRetry),
    .strobe(strobe), .winLane(winLane),
    .incTaken(incTaken), .incNotTaken(incNotTaken), .incViol(incViol)
  );

  redir_dpath #(
    .NT(NT), .L(L), .SEQ_W(SEQ_W), .PC_W(PC_W), .INST_BYTES(INST_BYTES),
    .CNT_W(CNT_W), .LIDX_W(LIDX_W)
  ) u_dpath (
    .clk(clk), .rst_n(rst_n),
    .laneSeq(laneSeq), .lanePc(lanePc), .laneNpc(laneNpc),
    .strobe(strobe), .winLane(winLane),
    .incTaken(incTaken), .incNotTaken(incNotTaken), .incViol(incViol),
    .squashOut(squashOut), .squashSeq(squashSeq),
    .restartPc(restartPc), .restartNpc(restartNpc),
    .mispredOut(mispredOut), .takenOut(takenOut), .includeOut(includeOut),
    .cntTakenMis(cntTakenMis), .cntNotTakenMis(cntNotTakenMis),
    .cntViolation(cntViolation)
  );

endmodule

// File: rtl/redir_checker.sv
module redir_checker #(
  parameter int NT         = 2,
  parameter int L          = 4,
  parameter int SEQ_W      = 16,
  parameter int PC_W       = 32,
  parameter int INST_BYTES = 4,
  parameter int CNT_W      = 16,
  parameter int TID_W      = 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [L-1:0]             laneValid,
  input logic [L-1:0][TID_W-1:0]  laneTid,
  input logic [L-1:0]             laneMispred,
  input logic [L-1:0]             laneViolation,
  input logic [L-1:0]             laneLoadBlocked,
  input logic [NT-1:0]            squashOut,
  input logic [NT-1:0][SEQ_W-1:0] squashSeq,
  input logic [NT-1:0][PC_W-1:0]  restartPc,
  input logic [NT-1:0][PC_W-1:0]  restartNpc,
  input logic [NT-1:0]            mispredOut,
  input logic [NT-1:0]            takenOut,
  input logic [NT-1:0]            includeOut,
  input logic [CNT_W-1:0]         cntTakenMis
);

  logic [NT-1:0] causeSeen;
  logic          armed;

  always_comb begin
    causeSeen = '0;
    for (int l = 0; l < L; l++)
      if (laneValid[l] && (laneMispred[l] || laneViolation[l] || laneLoadBlocked[l])
          && (int'(laneTid[l]) < NT))
        causeSeen[laneTid[l]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  for (genvar t = 0; t < NT; t++) begin : g_chk
    AST_NEXT_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      squashOut[t] |-> restartNpc[t] == restartPc[t] + PC_W'(INST_BYTES)); // R6
    AST_INCLUDE_ONLY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      includeOut[t] |-> (!mispredOut[t] && !takenOut[t] && squashOut[t])); // R5
    AST_TAKEN_NEEDS_MISPRED: assert property (@(posedge clk) disable iff (!rst_n)
      takenOut[t] |-> (mispredOut[t] && !includeOut[t])); // R3
    AST_IDLE_FIELDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !squashOut[t] |-> (!mispredOut[t] && !takenOut[t] && !includeOut[t]
                         && squashSeq[t] == '0 && restartPc[t] == '0)); // R8
    AST_SQUASH_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && squashOut[t]) |-> $past(causeSeen[t])); // R8
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> (cntTakenMis - $past(cntTakenMis)) <= CNT_W'(L)); // R9

endmodule

bind redirect_arbiter redir_checker #(
  .NT(NT), .L(L), .SEQ_W(SEQ_W), .PC_W(PC_W), .INST_BYTES(INST_BYTES),
  .CNT_W(CNT_W), .TID_W(TID_W)
) u_redir_checker (
  .clk(clk), .rst_n(rst_n),
  .laneValid(laneValid), .laneTid(laneTid), .laneMispred(laneMispred),
  .laneViolation(laneViolation), .laneLoadBlocked(laneLoadBlocked),
  .squashOut(squashOut), .squashSeq(squashSeq),
  .restartPc(restartPc), .restartNpc(restartNpc),
  .mispredOut(mispredOut), .takenOut(takenOut), .includeOut(includeOut),
  .cntTakenMis(cntTakenMis)
);

// File: tb/test_redirect_arbiter.sv
`timescale 1ns/1ps
module test_redirect_arbiter;

  localparam int NT = 2, L = 4, SEQ_W = 16, PC_W = 32, IB = 4, CNT_W = 16;
  localparam int TID_W = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [L-1:0]             laneValid, laneMispred, lanePredTaken, laneViolation, laneLoadBlocked;
  logic [L-1:0][TID_W-1:0]  laneTid;
  logic [L-1:0][SEQ_W-1:0]  laneSeq;
  logic [L-1:0][PC_W-1:0]   lanePc, laneNpc;
  logic [NT-1:0]            blockRetry;
  logic [NT-1:0]            squashOut, mispredOut, takenOut, includeOut;
  logic [NT-1:0][SEQ_W-1:0] squashSeq;
  logic [NT-1:0][PC_W-1:0]  restartPc, restartNpc;
  logic [CNT_W-1:0]         cntTakenMis, cntNotTakenMis, cntViolation;

  redirect_arbiter #(.NT(NT), .L(L), .SEQ_W(SEQ_W), .PC_W(PC_W), .INST_BYTES(IB),
                     .CNT_W(CNT_W)) i_redirect_arbiter (.*);

  always #4 clk = ~clk;  // 125 MHz

  int errors = 0, checks = 0;
  bit done = 1'b0;

  // bench model state
  logic [NT-1:0] handledM;
  logic [CNT_W-1:0] mTak, mNtk, mVio;
  int eCause [NT];        // 0 none 1 branch 2 order 3 load
  logic [NT-1:0] eSq, eMis, eTak, eInc;
  logic [NT-1:0][SEQ_W-1:0] eSeq;
  logic [NT-1:0][PC_W-1:0]  ePc, eNpc;

  task automatic clearLanes();
    laneValid = '0; laneMispred = '0; lanePredTaken = '0; laneViolation = '0;
    laneLoadBlocked = '0; laneTid = '0; laneSeq = '0; lanePc = '0; laneNpc = '0;
    blockRetry = '0;
  endtask

  task automatic setLane(int l, int tid, int seq, logic [PC_W-1:0] pc, logic [PC_W-1:0] npc,
                         bit mis, bit pt, bit vio, bit blk);
    laneValid[l] = 1'b1; laneTid[l] = TID_W'(tid); laneSeq[l] = SEQ_W'(seq);
    lanePc[l] = pc; laneNpc[l] = npc; laneMispred[l] = mis; lanePredTaken[l] = pt;
    laneViolation[l] = vio; laneLoadBlocked[l] = blk;
  endtask

  // expected outcome computed from R1..R10
  task automatic model();
    logic [NT-1:0] hm, rf;
    logic [NT-1:0][SEQ_W-1:0] rs;
    int wl [NT];
    hm = handledM & ~blockRetry; rf = '0; rs = '0;
    for (int t = 0; t < NT; t++) begin eCause[t] = 0; wl[t] = 0; end
    for (int l = 0; l < L; l++) begin
      if (laneValid[l]) begin
        int t, c;
        t = int'(laneTid[l]); c = 0;
        if (laneMispred[l]) c = 1;                                      // R2
        else if (laneViolation[l]) begin c = 2; mVio = mVio + 1'b1; end // R10
        else if (laneLoadBlocked[l] && !hm[t]) begin c = 3; hm[t] = 1'b1; end // R7
        if (c != 0 && (!rf[t] || laneSeq[l] < rs[t])) begin            // R1
          rf[t] = 1'b1; rs[t] = laneSeq[l]; eCause[t] = c; wl[t] = l;
          if (c == 1) begin
            if (lanePredTaken[l]) mTak = mTak + 1'b1; else mNtk = mNtk + 1'b1; // R9
          end
        end
      end
    end
    handledM = hm;
    for (int t = 0; t < NT; t++) begin
      int l;
      l = wl[t];
      eSq[t] = eCause[t] != 0;
      eSeq[t] = eSq[t] ? laneSeq[l] : '0;
      ePc[t] = (eCause[t] == 3) ? lanePc[l] : (eSq[t] ? laneNpc[l] : '0);
      eNpc[t] = eSq[t] ? ePc[t] + PC_W'(IB) : '0;                         // R6
      eMis[t] = eCause[t] == 1;
      eTak[t] = eCause[t] == 1 && laneNpc[l] != lanePc[l] + PC_W'(IB);
      eInc[t] = eCause[t] == 3;
    end
  endtask

  task automatic check(string tag);
    for (int t = 0; t < NT; t++) begin
      string rq;
      logic [SEQ_W+2*PC_W+3:0] act, exp;
      rq = tag;
      if (rq == "") rq = (eCause[t] == 1) ? "R3" : (eCause[t] == 2) ? "R4" :
                         (eCause[t] == 3) ? "R5" : "R8";
      act = {squashOut[t], squashSeq[t], restartPc[t], restartNpc[t], mispredOut[t], takenOut[t], includeOut[t]};
      exp = {eSq[t], eSeq[t], ePc[t], eNpc[t], eMis[t], eTak[t], eInc[t]};
      checks++;
      if (act !== exp) begin
        errors++;
        $display("FAIL %s thread %0d: actual %h expected %h", rq, t, act, exp);
      end
    end
    checks++;
    if ({cntTakenMis, cntNotTakenMis, cntViolation} !== {mTak, mNtk, mVio}) begin
      errors++;
      $display("FAIL R9/R10 counters: actual %h %h %h expected %h %h %h",
               cntTakenMis, cntNotTakenMis, cntViolation, mTak, mNtk, mVio);
    end
  endtask

  // inputs already set; apply at the edge and check one cycle later (R8 latency)
  task automatic step(string tag);
    model();
    @(posedge clk); #1;
    check(tag);
    @(negedge clk);
    clearLanes();
  endtask

  task automatic expectBit(string rq, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", rq, act, exp);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    clearLanes();
    handledM = '0; mTak = '0; mNtk = '0; mVio = '0;
    for (int t = 0; t < NT; t++) eCause[t] = 0;
    eSq = '0; eMis = '0; eTak = '0; eInc = '0; eSeq = '0; ePc = '0; eNpc = '0;
    repeat (3) @(negedge clk);
    check("R11");              // reset state
    rst_n = 1'b1;
    @(negedge clk);

    // R2: one lane with all three causes -> branch wins
    setLane(0, 0, 40, 32'h100, 32'h200, 1, 0, 1, 1);
    step("R2");
    expectBit("R2", mispredOut[0], 1'b1);
    @(negedge clk);

    // R1: older violation overrides younger mispredict; blocked load younger still
    setLane(0, 0, 50, 32'h300, 32'h304, 1, 1, 0, 0);
    setLane(1, 0, 20, 32'h400, 32'h500, 0, 0, 1, 0);
    setLane(2, 0, 30, 32'h600, 32'h604, 0, 0, 0, 1);
    step("R1");
    expectBit("R1", squashSeq[0] == 16'd20, 1'b1);

    // R7: load blocked handled above (lane 2 set the flag); again -> ignored
    setLane(0, 0, 60, 32'h700, 32'h704, 0, 0, 0, 1);
    step("R7");
    expectBit("R7", squashOut[0], 1'b0);
    setLane(0, 0, 61, 32'h700, 32'h704, 0, 0, 0, 1);
    blockRetry = 2'b01;
    step("R7");
    expectBit("R7", includeOut[0], 1'b1);

    // R12: traffic on thread 1 only
    setLane(3, 1, 9, 32'h800, 32'h900, 1, 0, 0, 0);
    step("R12");
    expectBit("R12", squashOut[0], 1'b0);

    // R3 not-taken mispredict (npc == pc+4) and R4 violation
    setLane(0, 1, 5, 32'hA00, 32'hA04, 1, 1, 0, 0);
    setLane(1, 0, 6, 32'hB00, 32'hC00, 0, 0, 1, 0);
    step("");
    expectBit("R3", takenOut[1], 1'b0);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      for (int l = 0; l < L; l++) begin
        if ($urandom_range(9) < 7) begin
          logic [PC_W-1:0] pc, npc;
          pc  = {$urandom} & 32'hFFFF_FFFC;
          npc = ($urandom_range(1) == 0) ? pc + 32'd4 : ({$urandom} & 32'hFFFF_FFFC);
          setLane(l, $urandom_range(NT-1), int'(($urandom & 32'hFFF8) | l), pc, npc,
                  $urandom_range(9) < 2, $urandom_range(1) == 1,
                  $urandom_range(19) < 3, $urandom_range(19) < 3);
        end
      end
      for (int t = 0; t < NT; t++) blockRetry[t] = $urandom_range(9) == 0;
      step("");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule